// File: doc/BRIEF.md
# Back-Porch Video Clamp Controller

This block sits behind up to four video ADCs and steers the analog clamp loop of each input. A pulse from the line timing marks the back porch of every line. While that pulse is high the block adds up the 9-bit samples of each channel, where code 511 is full scale. When the pulse ends it compares the mean of the collected samples with a per-channel black or mid-scale target code. A channel that sits too high gets a clamp-down request. A channel that sits too low gets a clamp-up request. A channel inside a small deadband around its target gets neither, which means hold.

The input mode sets the target for each channel. Composite luma clamps to code 120. Chroma and the two colour-difference components clamp to mid-scale, code 256. Component luma and the RGB primaries clamp to code 32. Each channel has an enable. A disabled channel never raises a request, so unused ADCs can be left floating. Requests are registered and last exactly one clock per line, so the analog charge pump can be driven straight from them.

Top module: `video_clamp_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, every upReq and downReq bit is 0.
- R2: If a channel's window mean is more than DEADBAND (default 2) codes above its target, that channel's downReq is 1 in the single clock cycle after the window pulse falls.
- R3: If a channel's window mean is more than DEADBAND codes below its target, that channel's upReq is 1 in that same cycle.
- R4: A mean within the target plus or minus DEADBAND, ends included, gives hold: upReq and downReq both 0. A mean of exactly target±2 holds; target±3 requests.
- R5: Targets by mode (3-bit code). Mode 0 (composite): all channels 120. Mode 1 (luma/chroma): ch0 120, ch1..ch3 256. Mode 2 (component): ch0 32, ch1 256, ch2 256, ch3 32. Mode 3 (RGB): all channels 32. Modes 4 to 7 behave like mode 0.
- R6: The decision uses the exact arithmetic mean of every sample taken during the window, not any single sample.
- R7: Samples presented while the window pulse is low have no effect on the decision.
- R8: A request lasts exactly one cycle. Requests occur only in the cycle after a clock edge where the window is seen low following an edge where it was seen high. At all other times every channel outputs hold.
- R9: A channel whose chanEn bit is 0 at the end of the window raises no request.
- R10: No channel ever raises upReq and downReq together.
- R11: Only the first WIN_MAX (default 255) samples of a window are averaged. Samples after that are ignored.
- R12: mode and chanEn are taken from the clock edge that closes the window, not from earlier in the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clampWin | input | 1 | Back-porch window pulse, high while samples are collected |
| mode | input | 3 | Input format selecting per-channel targets |
| chanEn | input | NUM_CH | Per-channel enable |
| samples | input | NUM_CH*SAMPLE_W | Channel samples, channel n in bits [n*9 +: 9] |
| upReq | output | NUM_CH | One-cycle clamp-up request per channel |
| downReq | output | NUM_CH | One-cycle clamp-down request per channel |

## Verification
The assertions check on every cycle that up and down are never raised together, that any request sits exactly one cycle after a window has closed and is gone a cycle later, and that no request appears on a channel that was disabled at the closing edge. Only the bench scenarios can show that the direction of each request is right. That covers the mode-dependent targets, the exact edges of the deadband, the averaging of mixed samples, the rejection of samples outside the window or beyond the WIN_MAX cap, and the point in time at which mode and enable are taken.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  typedef enum logic [2:0] {
    MODE_CVBS = 3'd0,
    MODE_YC   = 3'd1,
    MODE_COMP = 3'd2,
    MODE_RGB  = 3'd3
  } clamp_mode_e;

  localparam logic [8:0] LVL_LUMA  = 9'd120;
  localparam logic [8:0] LVL_MID   = 9'd256;
  localparam logic [8:0] LVL_BLACK = 9'd32;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // first sample of a window
    logic add;     // further sample accepted
    logic finish;  // window just closed: decide
  } clamp_strobe_t;

  function automatic logic [8:0] targetFor(input logic [2:0] modeSel, input int ch);
    logic [8:0] lvl;
    case (modeSel)
      MODE_YC:   lvl = (ch == 0) ? LVL_LUMA : LVL_MID;
      MODE_COMP: lvl = (ch == 1 || ch == 2) ? LVL_MID : LVL_BLACK;
      MODE_RGB:  lvl = LVL_BLACK;
      default:   lvl = LVL_LUMA;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/clamp_ctrl.sv
module clamp_ctrl
  import clamp_pkg::*;
#(
  parameter int WIN_MAX = 255,
  localparam int CNT_W = $clog2(WIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clampWin,
  output clamp_strobe_t    strobe,
  output logic [CNT_W-1:0] sampleCount
);

  logic winQ;
  logic [CNT_W-1:0] countQ;
  logic startWin;

  assign startWin      = clampWin & ~winQ;
  assign strobe.load   = startWin;
  assign strobe.add    = clampWin & ~winQ ? 1'b0
                       : clampWin & (countQ < CNT_W'(WIN_MAX));
  assign strobe.finish = winQ & ~clampWin;
  assign sampleCount   = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winQ   <= 1'b0;
      countQ <= '0;
    end else begin
      winQ <= clampWin;
      if (strobe.load)
        countQ <= CNT_W'(1);
      else if (strobe.add)
        countQ <= countQ + CNT_W'(1);
    end
  end

endmodule

// File: rtl/clamp_datapath.sv
module clamp_datapath
  import clamp_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 9,
  parameter int DEADBAND = 2,
  parameter int CNT_W    = 8,
  localparam int SUM_W  = SAMPLE_W + CNT_W,
  localparam int PROD_W = SAMPLE_W + 1 + CNT_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  clamp_strobe_t              strobe,
  input  logic [CNT_W-1:0]           sampleCount,
  input  logic [2:0]                 mode,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic [NUM_CH-1:0]          upReq,
  output logic [NUM_CH-1:0]          downReq
);

  logic [NUM_CH-1:0] wantUp;
  logic [NUM_CH-1:0] wantDown;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [SAMPLE_W-1:0] chSample;
    logic [SUM_W-1:0]    sumQ;
    logic [SAMPLE_W:0]   targetCode;
    logic [PROD_W-1:0]   hiLimit;
    logic [PROD_W-1:0]   loLimit;
    logic [PROD_W-1:0]   sumWide;

    assign chSample   = samples[g*SAMPLE_W +: SAMPLE_W];
    assign targetCode = (SAMPLE_W+1)'(targetFor(mode, g));
    // compare sum with (target +/- deadband) * count: exact mean test
    assign hiLimit = PROD_W'(targetCode + (SAMPLE_W+1)'(DEADBAND)) * PROD_W'(sampleCount);
    assign loLimit = PROD_W'(targetCode - (SAMPLE_W+1)'(DEADBAND)) * PROD_W'(sampleCount);
    assign sumWide = PROD_W'(sumQ);
    assign wantDown[g] = chanEn[g] & (sumWide > hiLimit);
    assign wantUp[g]   = chanEn[g] & (sumWide < loLimit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        sumQ <= '0;
      else if (strobe.load)
        sumQ <= SUM_W'(chSample);
      else if (strobe.add)
        sumQ <= sumQ + SUM_W'(chSample);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upReq   <= '0;
      downReq <= '0;
    end else if (strobe.finish) begin
      upReq   <= wantUp;
      downReq <= wantDown;
    end else begin
      upReq   <= '0;
      downReq <= '0;
    end
  end

endmodule

// File: rtl/video_clamp_ctrl.sv
module video_clamp_ctrl
  import clamp_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 9,
  parameter int DEADBAND = 2,
  parameter int WIN_MAX  = 255,
  localparam int CNT_W = $clog2(WIN_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clampWin,
  input  logic [2:0]                 mode,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  output logic [NUM_CH-1:0]          upReq,
  output logic [NUM_CH-1:0]          downReq
);

  clamp_strobe_t    strobe;
  logic [CNT_W-1:0] sampleCount;

  clamp_ctrl #(.WIN_MAX(WIN_MAX)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clampWin    (clampWin),
    .strobe      (strobe),
    .sampleCount (sampleCount)
  );

  clamp_datapath #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .DEADBAND (DEADBAND),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleCount (sampleCount),
    .mode        (mode),
    .chanEn      (chanEn),
    .samples     (samples),
    .upReq       (upReq),
    .downReq     (downReq)
  );

endmodule

// File: rtl/video_clamp_ctrl_checker.sv
module video_clamp_ctrl_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              clampWin,
  input logic [NUM_CH-1:0] chanEn,
  input logic [NUM_CH-1:0] upReq,
  input logic [NUM_CH-1:0] downReq
);

  assert_no_conflict_R10: assert property (@(posedge clk) disable iff (!rstN)
    (upReq & downReq) == '0);

  assert_after_close_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(upReq | downReq)) |-> (!$past(clampWin) && $past(clampWin, 2)));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|(upReq | downReq)) |=> ((upReq | downReq) == '0));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((upReq | downReq) & ~$past(chanEn)) == '0);

endmodule

bind video_clamp_ctrl video_clamp_ctrl_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .clampWin (clampWin),
  .chanEn   (chanEn),
  .upReq    (upReq),
  .downReq  (downReq)
);

// File: tb/video_clamp_ctrl_bench.sv
`timescale 1ns/1ps
module video_clamp_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clampWin = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [3:0]  chanEn = 4'h0;
  logic [35:0] samples = '0;
  logic [3:0]  upReq;
  logic [3:0]  downReq;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  video_clamp_ctrl u_video_clamp_ctrl (
    .clk(clk), .rstN(rstN), .clampWin(clampWin), .mode(mode),
    .chanEn(chanEn), .samples(samples), .upReq(upReq), .downReq(downReq)
  );

  typedef struct packed {
    logic [2:0] vMode;
    logic [3:0] vEn;
    logic [8:0] s3, s2, s1, s0;
    logic [3:0] vUp, vDown;
  } vec_t;

  // R2 R3 R4 R5 R9 vectors, 8-sample windows of constant samples
  localparam vec_t VECS [7] = '{
    '{3'd0, 4'hF, 9'd117, 9'd123, 9'd122, 9'd120, 4'b1000, 4'b0100},
    '{3'd1, 4'hF, 9'd259, 9'd258, 9'd254, 9'd118, 4'b0000, 4'b1000},
    '{3'd2, 4'hF, 9'd40,  9'd300, 9'd253, 9'd29,  4'b0011, 4'b1100},
    '{3'd3, 4'hF, 9'd35,  9'd30,  9'd34,  9'd32,  4'b0000, 4'b1000},
    '{3'd5, 4'hF, 9'd130, 9'd32,  9'd256, 9'd120, 4'b0100, 4'b1010},
    '{3'd0, 4'h5, 9'd0,   9'd0,   9'd200, 9'd200, 4'b0100, 4'b0001},
    '{3'd2, 4'h0, 9'd0,   9'd0,   9'd0,   9'd0,   4'b0000, 4'b0000}
  };

  task automatic check(input string tag, input logic [3:0] expUp, input logic [3:0] expDown);
    testsRun++;
    if (upReq !== expUp || downReq !== expDown) begin
      testsFailed++;
      $display("FAIL %s: up=%b down=%b expected up=%b down=%b",
               tag, upReq, downReq, expUp, expDown);
    end
  endtask

  // one window; sample set a or b chosen by parity (alt) or by index >= split
  task automatic runWin(input logic [2:0] m, input logic [3:0] en, input int len,
                        input int split, input bit alt,
                        input logic [35:0] a, input logic [35:0] b);
    mode = m;
    chanEn = en;
    for (int i = 0; i < len; i++) begin
      clampWin = 1'b1;
      samples = (alt ? i[0] : (i >= split)) ? b : a;
      @(negedge clk);
    end
    clampWin = 1'b0;
    samples = {4{9'd511}};
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    testsFailed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 in reset", 4'b0, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 4'b0, 4'b0);

    // vector table; outside-window samples are 511 (R7 hold elsewhere)
    for (int v = 0; v < 7; v++) begin
      samples = 36'h0;
      @(negedge clk);
      @(negedge clk);
      runWin(VECS[v].vMode, VECS[v].vEn, 8, 8, 1'b0,
             {VECS[v].s3, VECS[v].s2, VECS[v].s1, VECS[v].s0}, 36'h0);
      check($sformatf("R2/R3/R4/R5 vector %0d", v), VECS[v].vUp, VECS[v].vDown);
      @(negedge clk);
      check($sformatf("R8 pulse gone vector %0d", v), 4'b0, 4'b0);
    end

    // R6 averaging: ch0 116/125 ->120.5 hold, ch1 0/240 ->120 hold,
    // ch2 100/150 ->125 down, ch3 100/139 ->119.5 hold
    runWin(3'd0, 4'hF, 8, 0, 1'b1,
           {9'd100, 9'd100, 9'd0, 9'd116}, {9'd139, 9'd150, 9'd240, 9'd125});
    check("R6 mean of mixed samples", 4'b0000, 4'b0100);

    // R7: long run of out-of-range samples with window low, then window at target
    samples = 36'h0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 5) check("R8 hold outside window", 4'b0, 4'b0);
    end
    runWin(3'd0, 4'hF, 4, 4, 1'b0, {4{9'd120}}, 36'h0);
    check("R7 outside samples ignored", 4'b0, 4'b0);

    // R4 boundary: target+-2 hold, target+-3 act (mode 3, target 32)
    runWin(3'd3, 4'hF, 3, 3, 1'b0, {9'd29, 9'd35, 9'd30, 9'd34}, 36'h0);
    check("R4 deadband edges", 4'b1000, 4'b0100);

    // R11: 255 samples at 120 then 45 at 511 -> capped mean 120 holds
    runWin(3'd0, 4'h1, 300, 255, 1'b0, {4{9'd120}}, {4{9'd511}});
    check("R11 samples beyond cap ignored", 4'b0, 4'b0);

    // single-sample window
    runWin(3'd0, 4'h1, 1, 1, 1'b0, {27'd0, 9'd200}, 36'h0);
    check("R2 one-sample window", 4'b0, 4'b0001);

    // R12: mode 0 through the window, mode 3 on the closing edge, samples 32
    mode = 3'd0;
    chanEn = 4'h0;
    for (int i = 0; i < 6; i++) begin
      clampWin = 1'b1;
      samples = {4{9'd32}};
      @(negedge clk);
    end
    clampWin = 1'b0;
    mode = 3'd3;
    chanEn = 4'hF;
    @(negedge clk);
    check("R12 mode/enable taken at close", 4'b0, 4'b0);

    // R1: reset in mid-window cancels the decision
    runWin(3'd0, 4'hF, 2, 2, 1'b0, {4{9'd120}}, 36'h0);
    for (int i = 0; i < 3; i++) begin
      clampWin = 1'b1;
      samples = 36'h0;
      @(negedge clk);
    end
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-window", 4'b0, 4'b0);
    clampWin = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 no decision after reset", 4'b0, 4'b0);
    @(negedge clk);
    check("R1 still quiet", 4'b0, 4'b0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule